// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM. It has byte lanes, a built-in four-beat burst address generator and a registered read path. Every control, address and write-data input is sampled on the rising clock edge. A burst begins on one of two address strobes: a host strobe that always reads, or a controller strobe that reads or writes according to the write controls. After that, the burst advance input steps through the four words of an aligned group, or holds the current word, with no further addresses supplied.

Read data reaches the output register one edge after the address is captured. A combinational enable then gates it onto the bus. When the device is deselected, the last read word stays on the bus for one more cycle before the drive is released. A sleep input stops the block from accepting any command and turns the drive off, and the stored words are kept.

Top module: `pipelined_burst_sram`

## Requirements
- R1: A strobe only starts an access when `cs_main_n`=0, `cs_hi`=1 and `cs_lo_n`=0 are all true. A strobe that is taken while any of the three is false is a deselect: it causes no write, and it ends any burst in progress.
- R2: The word read at the address captured on edge N is on `rd_data`, with `rd_drive` high when enabled, from edge N+1 onward.
- R3: `strobe_host_n`=0 together with `cs_main_n`=0 starts a read burst whatever the write controls are. `strobe_host_n` has no effect while `cs_main_n`=1.
- R4: `strobe_ctrl_n`=0 on a selected device starts a burst. The burst writes if the lane mask from R6 is non-zero and reads otherwise. The host strobe has priority over the controller strobe.
- R5: In a cycle with no strobe and an active burst, `adv_n`=0 moves to the next burst word and `adv_n`=1 repeats the current word. The address bits above bit 1 stay at the start address. Bits [1:0] are (start+count) mod 4 when `burst_lin`=1, and start XOR count when `burst_lin`=0.
- R6: The lane mask is all lanes when `all_we_n`=0. Otherwise it is the lanes i with `lane_we_n[i]`=0, but only if `byte_en_n`=0; if not, it is empty. Lane i covers data bits [9i+8:9i].
- R7: A write stores the `wdata` value sampled on the same edge as the write command, and only in the lanes of the mask.
- R8: `oe_n`=1 turns `rd_drive` off at once, with no clock edge needed. It has no effect on stored data or on the pipeline.
- R9: On a deselect that follows a read, the output keeps driving the last word for one more cycle. It turns off after the next edge that retires a second deselect in a row. A write also turns the drive off.
- R10: While `sleep`=1, commands are ignored, the active burst ends, `rd_drive` is 0 and the memory contents are kept.
- R11: Synchronous reset `rst` clears the burst state and the output drive. The memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data |
| cs_main_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Depth-expansion select, active high |
| cs_lo_n | input | 1 | Depth-expansion select, active low |
| strobe_host_n | input | 1 | Host address strobe (read start), active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_en_n | input | 1 | Qualifier for the per-lane write enables, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| all_we_n | input | 1 | Write all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| rd_data | output | LANES*LANE_W | Registered read word |
| rd_drive | output | 1 | Bus drive enable for rd_data |

## Verification
A wrong burst counter or start register makes the wrong word appear on `rd_data` one edge after the access. A model that tracks every word exposes this on the first beat that goes wrong. A bad lane mask or write-data timing stays hidden in the array until that word is read back. The bench therefore fills the whole memory first and reads across every lane afterwards. Faults in the deselect or sleep state show up in `rd_drive` in the cycle they affect, because the drive flag is compared on every clock.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int BURST_CW = 2;

  // Low address bits of the current burst beat.
  function automatic logic [BURST_CW-1:0] burst_offset(
    input logic [BURST_CW-1:0] start,
    input logic [BURST_CW-1:0] count,
    input logic                linear
  );
    return linear ? (start + count) : (start ^ count);
  endfunction
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode #(
  parameter int LANES = 4
) (
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             strobe_host_n,
  input  logic             strobe_ctrl_n,
  input  logic             adv_n,
  input  logic             byte_en_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             all_we_n,
  input  logic             sleep,
  input  logic             burst_act,
  output logic             do_load,
  output logic             do_step,
  output logic             do_read,
  output logic             do_write,
  output logic             do_desel,
  output logic [LANES-1:0] wmask
);
  logic             chip_on;
  logic [LANES-1:0] req_mask;

  assign chip_on  = !cs_main_n && cs_hi && !cs_lo_n;
  assign req_mask = !all_we_n ? '1 : (!byte_en_n ? ~lane_we_n : '0);

  always_comb begin
    do_load  = 1'b0;
    do_step  = 1'b0;
    do_read  = 1'b0;
    do_write = 1'b0;
    do_desel = 1'b0;
    if (sleep) begin
      do_desel = 1'b1;
    end else if (!strobe_host_n && !cs_main_n) begin
      if (chip_on) begin
        do_load = 1'b1;
        do_read = 1'b1;
      end else begin
        do_desel = 1'b1;
      end
    end else if (!strobe_ctrl_n) begin
      if (chip_on) begin
        do_load  = 1'b1;
        do_write = |req_mask;
        do_read  = ~|req_mask;
      end else begin
        do_desel = 1'b1;
      end
    end else if (burst_act) begin
      do_step  = !adv_n;
      do_write = |req_mask;
      do_read  = ~|req_mask;
    end else begin
      do_desel = 1'b1;
    end
  end

  assign wmask = do_write ? req_mask : '0;
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0]       base_q;
  logic [BURST_CW-1:0] cnt_q;
  logic [BURST_CW-1:0] cnt_use;

  assign cnt_use = step ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_use;
    end
  end

  always_comb begin
    if (load) begin
      cur_addr = load_addr;
    end else begin
      cur_addr = {base_q[AW-1:BURST_CW],
                  burst_offset(base_q[BURST_CW-1:0], cnt_use, linear)};
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        wmask,
  input  logic                    re,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
        if (we && wmask[l]) cells[addr] <= wdata[l*LANE_W +: LANE_W];
        if (re) q <= cells[addr];
      end

      assign rdata[l*LANE_W +: LANE_W] = q;
    end
  endgenerate
endmodule

// File: rtl/pipelined_burst_sram.sv
module pipelined_burst_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             strobe_host_n,
  input  logic             strobe_ctrl_n,
  input  logic             adv_n,
  input  logic             byte_en_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             all_we_n,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic             burst_lin,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);
  logic             do_load, do_step, do_read, do_write, do_desel;
  logic [LANES-1:0] wmask;
  logic [AW-1:0]    cur_addr;
  logic             burst_act;

  // access stage: registered command of the current edge
  logic             a_rd, a_wr, a_desel;
  logic [AW-1:0]    a_addr;
  logic [LANES-1:0] a_mask;
  logic [DW-1:0]    a_wdata;

  // output stage
  logic             out_on, b_desel;

  sbsram_decode #(.LANES(LANES)) u_dec (
    .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .strobe_host_n(strobe_host_n), .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n(adv_n), .byte_en_n(byte_en_n), .lane_we_n(lane_we_n),
    .all_we_n(all_we_n), .sleep(sleep), .burst_act(burst_act),
    .do_load(do_load), .do_step(do_step), .do_read(do_read),
    .do_write(do_write), .do_desel(do_desel), .wmask(wmask)
  );

  sbsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .load(do_load), .step(do_step),
    .linear(burst_lin), .load_addr(addr), .cur_addr(cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)           burst_act <= 1'b0;
    else if (do_load)  burst_act <= 1'b1;
    else if (do_desel) burst_act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rd    <= 1'b0;
      a_wr    <= 1'b0;
      a_desel <= 1'b1;
      a_mask  <= '0;
    end else begin
      a_rd    <= do_read;
      a_wr    <= do_write;
      a_desel <= do_desel;
      a_mask  <= wmask;
    end
    a_addr  <= cur_addr;
    a_wdata <= wdata;
  end

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(a_wr), .wmask(a_mask), .re(a_rd),
    .addr(a_addr), .wdata(a_wdata), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      out_on  <= 1'b0;
      b_desel <= 1'b1;
    end else if (a_rd) begin
      out_on  <= 1'b1;
      b_desel <= 1'b0;
    end else if (a_wr) begin
      out_on  <= 1'b0;
      b_desel <= 1'b0;
    end else begin
      if (b_desel) out_on <= 1'b0;
      b_desel <= a_desel;
    end
  end

  assign rd_drive = out_on && !oe_n && !sleep;
endmodule

// File: rtl/sbsram_checker.sv
module sbsram_checker #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep,
  input logic          oe_n,
  input logic          rd_drive,
  input logic [DW-1:0] rd_data,
  input logic          cs_main_n,
  input logic          cs_hi,
  input logic          cs_lo_n,
  input logic          strobe_host_n,
  input logic          strobe_ctrl_n,
  input logic          a_rd,
  input logic          a_wr,
  input logic          a_desel,
  input logic          b_desel,
  input logic          out_on
);
  p_sel_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (!strobe_ctrl_n || !strobe_host_n) && !cs_main_n && (!cs_hi || cs_lo_n))
      |=> (a_desel && !a_rd && !a_wr));

  p_host_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_host_n && !cs_main_n && cs_hi && !cs_lo_n) |=> (a_rd && !a_wr));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (a_rd && !sleep) |=> out_on);

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rd_drive);

  p_sleep_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !rd_drive);

  p_sleep_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!a_rd && !a_wr));

  p_dcd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_on && a_desel && !b_desel && !sleep) |=> (out_on && $stable(rd_data)));

  p_dcd_off_r9: assert property (@(posedge clk) disable iff (rst)
    (a_desel && b_desel) |=> !out_on);
endmodule

bind pipelined_burst_sram sbsram_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .oe_n(oe_n), .rd_drive(rd_drive),
  .rd_data(rd_data), .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
  .strobe_host_n(strobe_host_n), .strobe_ctrl_n(strobe_ctrl_n),
  .a_rd(a_rd), .a_wr(a_wr), .a_desel(a_desel), .b_desel(b_desel), .out_on(out_on)
);

// File: tb/pipelined_burst_sram_test.sv
module pipelined_burst_sram_test;
  localparam int CLK_P  = 10;
  localparam int AW     = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic cs_main_n, cs_hi, cs_lo_n, strobe_host_n, strobe_ctrl_n, adv_n;
  logic byte_en_n, all_we_n, oe_n, sleep, burst_lin;
  logic [LANES-1:0] lane_we_n;
  logic [DW-1:0] rd_data;
  logic rd_drive;

  always #(CLK_P/2) clk = ~clk;

  pipelined_burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .cs_main_n(cs_main_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .strobe_host_n(strobe_host_n),
    .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n), .byte_en_n(byte_en_n),
    .lane_we_n(lane_we_n), .all_we_n(all_we_n), .oe_n(oe_n), .sleep(sleep),
    .burst_lin(burst_lin), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R11";

  // reference model state
  typedef struct {
    int               kind;   // 0 deselect, 1 read, 2 write
    int               a;
    logic [DW-1:0]    d;
    logic [LANES-1:0] m;
  } ev_t;
  ev_t           pend[$];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_data;
  bit            exp_on, prev_desel, m_act;
  int            m_base, m_cnt;

  function automatic logic [DW-1:0] pat(input int i);
    logic [8:0] b;
    b = 9'(i);
    return {b ^ 9'h1A5, b + 9'd77, ~b, b ^ 9'h0F0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    ev_t e, n;
    logic [LANES-1:0] m;
    bit sel;
    if (rst) begin
      pend.delete();
      exp_on = 0; prev_desel = 1; m_act = 0; m_base = 0; m_cnt = 0;
      return;
    end
    if (pend.size() > 0) e = pend.pop_front();
    else begin e.kind = 0; e.a = 0; e.d = '0; e.m = '0; end
    if (e.kind == 2)
      for (int l = 0; l < LANES; l++)
        if (e.m[l]) ref_mem[e.a][l*LANE_W +: LANE_W] = e.d[l*LANE_W +: LANE_W];
    if (e.kind == 1) exp_data = ref_mem[e.a];
    if (sleep) begin exp_on = 0; prev_desel = 1; end
    else if (e.kind == 1) begin exp_on = 1; prev_desel = 0; end
    else if (e.kind == 2) begin exp_on = 0; prev_desel = 0; end
    else begin
      if (prev_desel) exp_on = 0;
      prev_desel = 1;
    end
    // new command
    sel = (cs_main_n == 0) && (cs_hi == 1) && (cs_lo_n == 0);
    m = (all_we_n == 0) ? '1 : ((byte_en_n == 0) ? ~lane_we_n : '0);
    n.kind = 0; n.a = 0; n.d = wdata; n.m = m;
    if (sleep) m_act = 0;
    else if (strobe_host_n == 0 && cs_main_n == 0) begin
      if (sel) begin m_act = 1; m_base = int'(addr); m_cnt = 0; n.kind = 1; n.a = int'(addr); end
      else m_act = 0;
    end else if (strobe_ctrl_n == 0) begin
      if (sel) begin
        m_act = 1; m_base = int'(addr); m_cnt = 0; n.a = int'(addr);
        n.kind = (m != 0) ? 2 : 1;
      end else m_act = 0;
    end else if (m_act) begin
      if (adv_n == 0) m_cnt = (m_cnt + 1) % 4;
      n.a = (m_base & ~3) | (burst_lin ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt));
      n.kind = (m != 0) ? 2 : 1;
    end
    pend.push_back(n);
  endtask

  task automatic compare();
    bit ed;
    ed = exp_on && !oe_n && !sleep;
    chk(rd_drive === ed, cur_req, "drive", DW'(rd_drive), DW'(ed));
    if (ed) chk(rd_data === exp_data, cur_req, "data", rd_data, exp_data);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_idle();
    cs_main_n = 0; cs_hi = 1; cs_lo_n = 0;
    strobe_host_n = 1; strobe_ctrl_n = 1; adv_n = 1;
    byte_en_n = 1; lane_we_n = '1; all_we_n = 1;
    sleep = 0; oe_n = 0;
  endtask

  task automatic cmd_ctrl(input int a, input logic [DW-1:0] d, input logic gw_n,
                          input logic be_n, input logic [LANES-1:0] ln);
    addr = AW'(a); wdata = d; strobe_ctrl_n = 0;
    all_we_n = gw_n; byte_en_n = be_n; lane_we_n = ln;
    tick();
    set_idle();
  endtask

  task automatic cmd_host(input int a, input logic gw_n);
    addr = AW'(a); strobe_host_n = 0; all_we_n = gw_n; wdata = '1;
    tick();
    set_idle();
  endtask

  task automatic cmd_desel();
    strobe_ctrl_n = 0; cs_hi = 0;
    tick();
    set_idle();
  endtask

  task automatic cmd_cont(input logic adv);
    adv_n = adv;
    tick();
    set_idle();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] old, nw, want;
    rst = 1; addr = '0; wdata = '0; burst_lin = 1;
    set_idle();
    repeat (3) tick();
    rst = 0;
    cur_req = "R11";
    chk(rd_drive == 0, "R11", "drive after reset", DW'(rd_drive), '0);

    // fill the array with global writes
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) cmd_ctrl(i, pat(i), 0, 1, '1);
    cmd_desel(); cmd_desel();

    // R2: one-cycle read latency
    cur_req = "R2";
    cmd_ctrl(5, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == pat(5), "R2", "read latency", rd_data, pat(5));

    // R9: double-cycle deselect
    cur_req = "R9";
    cmd_host(9, 1);
    cmd_desel();
    chk(rd_drive && rd_data == pat(9), "R9", "first cycle", rd_data, pat(9));
    cmd_desel();
    chk(rd_drive && rd_data == pat(9), "R9", "held one more", rd_data, pat(9));
    cmd_desel();
    chk(rd_drive == 0, "R9", "released", DW'(rd_drive), '0);

    // R3: host strobe reads despite write controls; ignored with cs_main_n high
    cur_req = "R3";
    cmd_host(12, 0);
    cmd_desel();
    chk(rd_drive && rd_data == pat(12), "R3", "host read", rd_data, pat(12));
    burst_lin = 1;
    cmd_ctrl(20, '0, 1, 1, '1);
    cs_main_n = 1; strobe_host_n = 0; adv_n = 0; addr = 8'd99;
    tick(); set_idle();
    cmd_desel();
    chk(rd_drive && rd_data == pat(21), "R3", "host strobe ignored", rd_data, pat(21));

    // R5: burst orders and suspend
    cur_req = "R5";
    burst_lin = 1;
    cmd_ctrl(5, '0, 1, 1, '1);
    cmd_cont(0); cmd_cont(1); cmd_cont(0); cmd_cont(0);
    cmd_desel();
    chk(rd_drive && rd_data == pat(4), "R5", "linear last beat", rd_data, pat(4));
    cmd_desel(); cmd_desel();
    burst_lin = 0;
    cmd_ctrl(5, '0, 1, 1, '1);
    cmd_cont(0); cmd_cont(0); cmd_cont(0);
    cmd_desel();
    chk(rd_drive && rd_data == pat(6), "R5", "interleaved last beat", rd_data, pat(6));
    cmd_cont(1);
    burst_lin = 1;

    // R6/R4: byte writes, lanes 1 and 3 enabled (lane_we_n=0101)
    cur_req = "R6";
    nw = {4{9'h1C3}};
    cmd_ctrl(40, nw, 1, 0, 4'b0101);
    old = pat(40);
    want = {nw[35:27], old[26:18], nw[17:9], old[8:0]};
    cmd_ctrl(40, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == want, "R6", "lane merge", rd_data, want);
    cur_req = "R4";
    cmd_ctrl(41, '0, 1, 1, 4'b0000);
    cmd_ctrl(41, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == pat(41), "R4", "unqualified lanes read", rd_data, pat(41));

    // R7: write data from same edge, then read back
    cur_req = "R7";
    cmd_ctrl(50, 36'h9_8765_4321, 0, 1, '1);
    cmd_ctrl(50, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == 36'h9_8765_4321, "R7", "write readback", rd_data, 36'h9_8765_4321);

    // R8: asynchronous output enable
    cur_req = "R8";
    oe_n = 1; #1;
    chk(rd_drive == 0, "R8", "oe off mid cycle", DW'(rd_drive), '0);
    oe_n = 0; #1;
    chk(rd_drive == 1, "R8", "oe on mid cycle", DW'(rd_drive), DW'(1));

    // R10: sleep ignores commands, keeps data
    cur_req = "R10";
    sleep = 1; addr = 8'd60; wdata = '0; strobe_ctrl_n = 0; all_we_n = 0;
    tick(); tick(); tick();
    chk(rd_drive == 0, "R10", "drive in sleep", DW'(rd_drive), '0);
    set_idle();
    cmd_ctrl(60, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == pat(60), "R10", "contents kept", rd_data, pat(60));

    // R1: a deselected strobe does not write
    cur_req = "R1";
    cs_lo_n = 1; cmd_ctrl(70, '0, 0, 1, '1);
    cs_hi = 0;   cmd_ctrl(70, '0, 0, 1, '1);
    cmd_ctrl(70, '0, 1, 1, '1);
    cmd_desel();
    chk(rd_drive && rd_data == pat(70), "R1", "no write when deselected", rd_data, pat(70));

    // mixed random traffic against the model
    cur_req = "mix";
    for (int k = 0; k < 600; k++) begin
      cs_main_n = ($urandom % 8) == 0;
      cs_hi = ($urandom % 8) != 0;
      cs_lo_n = ($urandom % 8) == 0;
      strobe_host_n = ($urandom % 5) != 0;
      strobe_ctrl_n = ($urandom % 4) != 0;
      adv_n = 1'($urandom);
      all_we_n = ($urandom % 5) != 0;
      byte_en_n = 1'($urandom);
      lane_we_n = LANES'($urandom);
      addr = AW'($urandom);
      wdata = {4'($urandom), 32'($urandom)};
      sleep = ($urandom % 12) == 0;
      oe_n = ($urandom % 8) == 0;
      burst_lin = 1'($urandom);
      tick();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule